// File: doc/BRIEF.md
# Grouped Carry-Lookahead Adder

This block adds two unsigned operands and a carry-in, producing a sum of the same width and a carry-out. It is purely combinational. Every bit position forms a generate term and a propagate term. The operand is cut into 4-bit slices. Each slice computes all of its internal carries and its outgoing carry in one flat sum-of-products level, taken from those terms and the slice's incoming carry. No carry steps from bit to bit inside a slice.

Only the slice carries pass serially: each slice's carry-out feeds the carry-in of the next more significant slice. The most significant slice's carry-out is the adder's carry-out. The default build is 12 bits wide, which gives three slices. The width must be a whole multiple of 4, and elaboration stops with an error if it is not.

A parameter selects whether the carry logic uses the inclusive-OR or the exclusive-OR form of propagate. Both forms give the same carries. The sum bits always use the exclusive-OR half-sum.

Top module: `gcla_adder`

## Requirements
- R1: For every pair of operands and carry-in, {carry_o, sum_o} equals the arithmetic value a_i + b_i + carry_i, taken over WIDTH+1 bits.
- R2: When every bit of the operands differs (a_i is all ones and b_i is zero), the incoming carry travels through all slices unchanged: carry_i=1 gives sum 0 with carry_o=1, and carry_i=0 gives all ones with carry_o=0.
- R3: A slice whose top bit has both operand bits at 1 sends a carry into the next slice whatever its incoming carry is, so 0x008 + 0x008 gives 0x010.
- R4: A bit with both operand bits at 0 stops an arriving carry. With 0x007 + 0x000 and carry_i=1, the result is 0x008 and no carry leaves the lowest slice.
- R5: carry_o is the carry leaving the most significant bit, so 0x800 + 0x800 gives sum 0x000 with carry_o=1.
- R6: carry_i enters at bit 0, so 0 + 0 with carry_i=1 gives sum 0x001 and carry_o=0.
- R7: All ones plus all ones plus carry_i=1 gives sum all ones with carry_o=1, and both propagate forms (OR_PROP 0 and 1) give identical results for every input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand, unsigned |
| b_i | input | WIDTH | Second operand, unsigned |
| carry_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum bits |
| carry_o | output | 1 | Carry out of the most significant bit |

## Verification
The adder holds no register, so each result is due in the same cycle as its operands, once the combinational logic has settled. The bench changes the operands on the falling clock edge and samples the outputs 5 ns later. That sample lands well before the next rising edge and long after the inputs changed. Each vector from the table, each directed corner case and each random vector is checked against the sum computed in the bench with a behavioural add. A second instance built with the other propagate form is checked against the same expected values.

// File: rtl/gcla_pkg.sv
package gcla_pkg;

  // Slice width of the lookahead logic; the equations below are written for it.
  localparam int unsigned SLICE_W = 4;

  // Per-bit carry terms.
  typedef struct packed {
    logic gen;   // bit creates a carry
    logic prp;   // bit passes an arriving carry
    logic hsum;  // exclusive-OR of the two operand bits
  } bit_terms_t;

  // Slice-level generate and propagate.
  typedef struct packed {
    logic gen;
    logic prp;
  } slice_terms_t;

  // Per-bit terms; or_form selects inclusive-OR propagate.
  function automatic bit_terms_t bit_terms(input logic a, input logic b,
                                           input logic or_form);
    bit_terms_t t;
    t.gen  = a & b;
    t.hsum = a ^ b;
    t.prp  = or_form ? (a | b) : (a ^ b);
    return t;
  endfunction

  // Flat lookahead: element k is the carry into bit k; element 4 leaves the slice.
  function automatic logic [SLICE_W:0] slice_carries(input logic [SLICE_W-1:0] g,
                                                     input logic [SLICE_W-1:0] p,
                                                     input logic cin);
    logic [SLICE_W:0] c;
    c[0] = cin;
    c[1] = g[0]
         | (cin & p[0]);
    c[2] = g[1]
         | (g[0] & p[1])
         | (cin & p[0] & p[1]);
    c[3] = g[2]
         | (g[1] & p[2])
         | (g[0] & p[1] & p[2])
         | (cin & p[0] & p[1] & p[2]);
    c[4] = g[3]
         | (g[2] & p[3])
         | (g[1] & p[2] & p[3])
         | (g[0] & p[1] & p[2] & p[3])
         | (cin & p[0] & p[1] & p[2] & p[3]);
    return c;
  endfunction

  // Slice generate/propagate, independent of the incoming carry.
  function automatic slice_terms_t slice_terms(input logic [SLICE_W-1:0] g,
                                               input logic [SLICE_W-1:0] p);
    slice_terms_t s;
    s.gen = g[3]
          | (g[2] & p[3])
          | (g[1] & p[2] & p[3])
          | (g[0] & p[1] & p[2] & p[3]);
    s.prp = &p;
    return s;
  endfunction

endpackage

// File: rtl/gcla_bit_pg.sv
module gcla_bit_pg
  import gcla_pkg::*;
#(
  parameter bit OR_PROP = 1'b0
) (
  input  logic a,
  input  logic b,
  output logic gen,
  output logic prp,
  output logic hsum
);

  bit_terms_t terms;

  always_comb begin
    terms = bit_terms(a, b, OR_PROP);
  end

  assign gen  = terms.gen;
  assign prp  = terms.prp;
  assign hsum = terms.hsum;

endmodule

// File: rtl/gcla_sum_xor.sv
module gcla_sum_xor #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] hsum,
  input  logic [W-1:0] carry_in_bits,
  output logic [W-1:0] sum
);

  for (genvar i = 0; i < W; i++) begin : g_sbit
    assign sum[i] = hsum[i] ^ carry_in_bits[i];
  end

endmodule

// File: rtl/gcla_slice.sv
module gcla_slice
  import gcla_pkg::*;
#(
  parameter bit OR_PROP = 1'b0
) (
  input  logic [SLICE_W-1:0] a,
  input  logic [SLICE_W-1:0] b,
  input  logic               cin,
  output logic [SLICE_W-1:0] sum,
  output logic               cout,
  output logic               slice_gen,
  output logic               slice_prp
);

  logic [SLICE_W-1:0] g;
  logic [SLICE_W-1:0] p;
  logic [SLICE_W-1:0] hs;
  logic [SLICE_W:0]   c;
  slice_terms_t       st;

  for (genvar i = 0; i < SLICE_W; i++) begin : g_bit
    gcla_bit_pg #(.OR_PROP(OR_PROP)) u_pg (
      .a    (a[i]),
      .b    (b[i]),
      .gen  (g[i]),
      .prp  (p[i]),
      .hsum (hs[i])
    );
  end

  // Every carry comes from its own flat term; none is taken from a neighbour.
  always_comb begin
    c  = slice_carries(g, p, cin);
    st = slice_terms(g, p);
  end

  gcla_sum_xor #(.W(SLICE_W)) u_sum (
    .hsum          (hs),
    .carry_in_bits (c[SLICE_W-1:0]),
    .sum           (sum)
  );

  assign cout      = c[SLICE_W];
  assign slice_gen = st.gen;
  assign slice_prp = st.prp;

endmodule

// File: rtl/gcla_adder.sv
module gcla_adder
  import gcla_pkg::*;
#(
  parameter int unsigned WIDTH   = 12,
  parameter bit          OR_PROP = 1'b0
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o
);

  localparam int unsigned NSLICE = WIDTH / SLICE_W;

  if ((WIDTH % SLICE_W) != 0 || WIDTH == 0) begin : g_bad_width
    $error("gcla_adder: WIDTH must be a nonzero multiple of 4");
  end

  // Slice-boundary carries: element k enters slice k; element NSLICE leaves the top.
  logic [NSLICE:0]   slc_carry;
  logic [NSLICE-1:0] slc_gen;
  logic [NSLICE-1:0] slc_prp;

  assign slc_carry[0] = carry_i;

  for (genvar k = 0; k < NSLICE; k++) begin : g_slice
    gcla_slice #(.OR_PROP(OR_PROP)) u_slice (
      .a         (a_i[k*SLICE_W +: SLICE_W]),
      .b         (b_i[k*SLICE_W +: SLICE_W]),
      .cin       (slc_carry[k]),
      .sum       (sum_o[k*SLICE_W +: SLICE_W]),
      .cout      (slc_carry[k+1]),
      .slice_gen (slc_gen[k]),
      .slice_prp (slc_prp[k])
    );
  end

  assign carry_o = slc_carry[NSLICE];

endmodule

// File: rtl/gcla_adder_chk.sv
module gcla_adder_chk #(
  parameter int unsigned WIDTH  = 12,
  parameter int unsigned NSLICE = 3
) (
  input logic [WIDTH-1:0]  a_i,
  input logic [WIDTH-1:0]  b_i,
  input logic              carry_i,
  input logic [WIDTH-1:0]  sum_o,
  input logic              carry_o,
  input logic [NSLICE:0]   slc_carry,
  input logic [NSLICE-1:0] slc_gen,
  input logic [NSLICE-1:0] slc_prp
);

  logic [WIDTH:0] total;

  always_comb begin
    total = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, carry_i};

    p_full_sum_r1: assert ({carry_o, sum_o} == total)
      else $error("R1: result %h expected %h", {carry_o, sum_o}, total);

    for (int k = 0; k < int'(NSLICE); k++) begin
      // R2: flat carry agrees with the slice's own generate/propagate.
      p_slice_chain_r2: assert (slc_carry[k+1] ==
                                (slc_gen[k] | (slc_prp[k] & slc_carry[k])))
        else $error("R2: slice %0d carry mismatch", k);

      p_top_gen_r3: assert (!(a_i[k*4+3] & b_i[k*4+3]) || slc_carry[k+1])
        else $error("R3: slice %0d top bit generates but no carry", k);

      p_top_kill_r4: assert ((a_i[k*4+3] | b_i[k*4+3]) || !slc_carry[k+1])
        else $error("R4: slice %0d top bit kills but carry seen", k);
    end

    p_msb_carry_r5: assert (carry_o ==
                            ((a_i[WIDTH-1] & b_i[WIDTH-1]) |
                             ((a_i[WIDTH-1] | b_i[WIDTH-1]) & ~sum_o[WIDTH-1])))
      else $error("R5: carry_o disagrees with the most significant bit");
  end

endmodule

bind gcla_adder gcla_adder_chk #(
  .WIDTH  (WIDTH),
  .NSLICE (NSLICE)
) u_chk (
  .a_i       (a_i),
  .b_i       (b_i),
  .carry_i   (carry_i),
  .sum_o     (sum_o),
  .carry_o   (carry_o),
  .slc_carry (slc_carry),
  .slc_gen   (slc_gen),
  .slc_prp   (slc_prp)
);

// File: tb/gcla_adder_test.sv
module gcla_adder_test;

  localparam int unsigned W = 12;
  localparam int unsigned NVEC = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic [W-1:0] a, b;
  logic         ci;
  wire  [W-1:0] s_x, s_o;
  wire          co_x, co_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  gcla_adder #(.WIDTH(W), .OR_PROP(1'b0)) uut (
    .a_i(a), .b_i(b), .carry_i(ci), .sum_o(s_x), .carry_o(co_x));

  gcla_adder #(.WIDTH(W), .OR_PROP(1'b1)) uut_or (
    .a_i(a), .b_i(b), .carry_i(ci), .sum_o(s_o), .carry_o(co_o));

  // {a, b, carry_i, expected sum, expected carry_o}
  localparam logic [37:0] VECS [NVEC] = '{
    {12'h000, 12'h000, 1'b0, 12'h000, 1'b0},  // R1 zero
    {12'hFFF, 12'h000, 1'b1, 12'h000, 1'b1},  // R2 carry through all slices
    {12'hFFF, 12'h000, 1'b0, 12'hFFF, 1'b0},  // R2 no carry
    {12'h008, 12'h008, 1'b0, 12'h010, 1'b0},  // R3 top-bit generate
    {12'h007, 12'h000, 1'b1, 12'h008, 1'b0},  // R4 kill at bit 3
    {12'h800, 12'h800, 1'b0, 12'h000, 1'b1},  // R5 carry out of MSB
    {12'h000, 12'h000, 1'b1, 12'h001, 1'b0},  // R6 carry in at bit 0
    {12'hFFF, 12'hFFF, 1'b1, 12'hFFF, 1'b1},  // R7 all ones
    {12'h123, 12'h456, 1'b0, 12'h579, 1'b0},  // R1 no carries
    {12'hABC, 12'hDEF, 1'b1, 12'h8AC, 1'b1},  // R1 mixed
    {12'h0F0, 12'h0F0, 1'b0, 12'h1E0, 1'b0},  // R3 middle slice generates
    {12'h7FF, 12'h001, 1'b0, 12'h800, 1'b0}   // R2 long propagate
  };

  task automatic check(input string req, input logic [W-1:0] es, input logic ec);
    checks++;
    if (s_x !== es || co_x !== ec) begin
      errors++;
      $display("FAIL %s: a=%h b=%h ci=%b got %b_%h expected %b_%h",
               req, a, b, ci, co_x, s_x, ec, es);
    end
    checks++;
    if (s_o !== es || co_o !== ec) begin
      errors++;
      $display("FAIL %s (OR form, R7): a=%h b=%h ci=%b got %b_%h expected %b_%h",
               req, a, b, ci, co_o, s_o, ec, es);
    end
  endtask

  // Drive on the falling edge, sample 5 ns later, before the next rising edge.
  task automatic apply(input logic [W-1:0] va, input logic [W-1:0] vb, input logic vc);
    @(negedge clk);
    a  = va;
    b  = vb;
    ci = vc;
    #5;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W:0] ref_sum;
    a = '0; b = '0; ci = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Reset state: zero inputs give zero outputs (R1).
    apply('0, '0, 1'b0);
    check("R1 reset", 12'h000, 1'b0);

    for (int i = 0; i < int'(NVEC); i++) begin
      apply(VECS[i][37:26], VECS[i][25:14], VECS[i][13]);
      check("R1-table", VECS[i][12:1], VECS[i][0]);
    end

    // Directed corner cases: all ones with each carry-in.
    apply(12'hFFF, 12'h000, 1'b1); check("R2", 12'h000, 1'b1);
    apply(12'h000, 12'hFFF, 1'b1); check("R2", 12'h000, 1'b1);
    apply(12'hFFF, 12'h001, 1'b0); check("R5", 12'h000, 1'b1);
    apply(12'h088, 12'h088, 1'b1); check("R3", 12'h111, 1'b0);
    apply(12'h077, 12'h000, 1'b1); check("R4", 12'h078, 1'b0);
    apply(12'hFFF, 12'hFFF, 1'b0); check("R7", 12'hFFE, 1'b1);
    apply(12'h000, 12'h000, 1'b1); check("R6", 12'h001, 1'b0);

    // Random vectors against a behavioural add.
    for (int n = 0; n < 600; n++) begin
      logic [W-1:0] ra, rb;
      logic rc;
      ra = W'($urandom);
      rb = W'($urandom);
      rc = 1'($urandom);
      ref_sum = {1'b0, ra} + {1'b0, rb} + {{W{1'b0}}, rc};
      apply(ra, rb, rc);
      check("R1 random", ref_sum[W-1:0], ref_sum[W]);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule